// File: doc/BRIEF.md
# Bidirectional Handshake Port with Interrupt

This block is one 8-bit peripheral port that carries data both ways over a single shared peripheral bus, with a full handshake in each direction. On the CPU side there are read and write strobes and the two data paths. On the peripheral side there are the shared bus, a strobe input and an acknowledge input.

In the outbound direction, a CPU write latches a byte and raises an output-buffer-full flag. The peripheral asserts acknowledge to take the byte. While acknowledge is asserted the port drives the bus, and when acknowledge is released the flag clears.

In the inbound direction, the peripheral asserts strobe. The port then captures the bus into an input latch and sets an input-buffer-full flag. That flag clears when the CPU finishes reading the port.

Each direction has its own interrupt-enable flip-flop, and both terms feed one interrupt request. The enables are written through single-bit set/reset commands that address bit numbers of the companion control port. A mode-selection pulse returns the handshake to idle. The peripheral strobe and acknowledge are asynchronous, so they are synchronised to the system clock before their edges are detected.

Top module: `bidir_hs_port`

## Requirements
- R1: After reset, obf_n is 1, ibf is 0, intr is 0, per_bus_oe is 0, and both interrupt enables are cleared.
- R2: The first cycle of a CPU write (rising cpu_wr) latches cpu_wdata into the output latch and drives obf_n low.
- R3: per_bus_oe is high, and per_bus_out carries the output latch, only while the synchronised acknowledge (per_ack_n low) is asserted.
- R4: When the synchronised acknowledge is released (per_ack_n rises), obf_n returns to 1.
- R5: When the synchronised strobe is asserted (per_stb_n falls), the port captures per_bus_in into the input latch, sets ibf, and shows the latch on cpu_rdata.
- R6: The end of a CPU read (falling cpu_rd) clears ibf.
- R7: A set/reset command with bsr_valid=1 and bsr_bit=6 writes bsr_val (1 = set, 0 = clear) into the output interrupt enable. bsr_bit=4 does the same for the input interrupt enable. Any other bsr_bit value leaves both enables unchanged.
- R8: The input term of intr is high when ibf is 1, the input enable is set, the synchronised strobe is inactive and cpu_rd is low.
- R9: The output term of intr is high when obf_n is 0, the output enable is set, the synchronised acknowledge is inactive and cpu_wr is low.
- R10: intr drops in the same cycle that cpu_rd or cpu_wr rises, without waiting for a clock edge.
- R11: A mode_set pulse clears both interrupt enables and the output latch, sets obf_n to 1, and clears ibf.
- R12: The two handshakes run independently. A write may come before its acknowledge and a strobe before its read, interleaved in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write of the port, active high, may last several cycles |
| cpu_rd | input | 1 | CPU read of the port, active high, may last several cycles |
| cpu_wdata | input | W | Data written by the CPU |
| cpu_rdata | output | W | Input latch as seen by the CPU |
| mode_set | input | 1 | Mode-selection pulse, returns the handshake to idle |
| bsr_valid | input | 1 | Bit set/reset command strobe |
| bsr_bit | input | 3 | Bit number addressed by the command |
| bsr_val | input | 1 | 1 sets, 0 clears the addressed bit |
| per_stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| per_ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| per_bus_in | input | W | Shared bus value as seen at the pins |
| per_bus_out | output | W | Value the port drives onto the shared bus |
| per_bus_oe | output | 1 | Output enable for the shared bus |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request |

## Verification
The bench builds the port with W=8 and SYNC=3. The deeper synchroniser stretches the delay from a strobe or acknowledge pin change to the flag change to four clock edges. The checks therefore wait out a latency longer than the default before sampling, and they confirm that the flags do not move early. With eight data bits, alternating and boundary patterns such as 0xA5, 0x5A, 0xFF and 0x00 can travel both ways over the shared bus in interleaved orders. The same width makes the output latch clear after a mode selection visible as a zero on the bus.

// File: rtl/bidir_hs_port.sv
module bidir_hs_port #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_wr,
  input  logic         cpu_rd,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  input  logic         mode_set,
  input  logic         bsr_valid,
  input  logic [2:0]   bsr_bit,
  input  logic         bsr_val,
  input  logic         per_stb_n,
  input  logic         per_ack_n,
  input  logic [W-1:0] per_bus_in,
  output logic [W-1:0] per_bus_out,
  output logic         per_bus_oe,
  output logic         obf_n,
  output logic         ibf,
  output logic         intr
);

  localparam logic [2:0] OUT_EN_BIT = 3'd6;
  localparam logic [2:0] IN_EN_BIT  = 3'd4;

  logic [SYNC-1:0] stb_sh, ack_sh;
  logic            stb_d, ack_d, wr_d, rd_d;
  logic            inte_o, inte_i, obf_q, ibf_q;
  logic [W-1:0]    out_q, in_q;

  wire stb_s    = stb_sh[SYNC-1];
  wire ack_s    = ack_sh[SYNC-1];
  wire stb_hit  = stb_s & ~stb_d;
  wire ack_rel  = ~ack_s & ack_d;
  wire wr_start = cpu_wr & ~wr_d;
  wire rd_end   = ~cpu_rd & rd_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_sh <= '0;
      ack_sh <= '0;
      stb_d  <= 1'b0;
      ack_d  <= 1'b0;
      wr_d   <= 1'b0;
      rd_d   <= 1'b0;
      inte_o <= 1'b0;
      inte_i <= 1'b0;
      obf_q  <= 1'b0;
      ibf_q  <= 1'b0;
      out_q  <= '0;
      in_q   <= '0;
    end else begin
      stb_sh <= {stb_sh[SYNC-2:0], ~per_stb_n};
      ack_sh <= {ack_sh[SYNC-2:0], ~per_ack_n};
      stb_d  <= stb_s;
      ack_d  <= ack_s;
      wr_d   <= cpu_wr;
      rd_d   <= cpu_rd;
      if (mode_set) begin
        inte_o <= 1'b0;
        inte_i <= 1'b0;
        obf_q  <= 1'b0;
        ibf_q  <= 1'b0;
        out_q  <= '0;
      end else begin
        if (bsr_valid && bsr_bit == OUT_EN_BIT) inte_o <= bsr_val;
        if (bsr_valid && bsr_bit == IN_EN_BIT)  inte_i <= bsr_val;
        if (wr_start) begin
          out_q <= cpu_wdata;
          obf_q <= 1'b1;
        end else if (ack_rel) begin
          obf_q <= 1'b0;
        end
        if (stb_hit) begin
          in_q  <= per_bus_in;
          ibf_q <= 1'b1;
        end else if (rd_end) begin
          ibf_q <= 1'b0;
        end
      end
    end
  end

  assign cpu_rdata   = in_q;
  assign per_bus_out = out_q;
  assign per_bus_oe  = ack_s;
  assign obf_n       = ~obf_q;
  assign ibf         = ibf_q;
  assign intr        = (ibf_q & inte_i & ~stb_s & ~cpu_rd) |
                       (obf_q & inte_o & ~ack_s & ~cpu_wr);

  assert_write_sets_obf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_wr) && !mode_set) |=> !obf_n);

  assert_obf_release_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf_n) |-> ($past(mode_set) || $past(ack_d)));

  assert_ibf_clear_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ibf) |-> ($past(mode_set) || $past(rd_d)));

  assert_no_intr_in_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_wr) |-> !intr);

  assert_mode_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (obf_n && !ibf && !intr));

  assert_stb_sets_ibf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_hit && !mode_set) |=> ibf);

endmodule

// File: tb/test_bidir_hs_port.sv
module test_bidir_hs_port;
  localparam int W = 8;
  localparam int SYNC = 3;
  localparam int LAT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, mode_set = 1'b0;
  logic bsr_valid = 1'b0, bsr_val = 1'b0;
  logic [2:0] bsr_bit = '0;
  logic [W-1:0] cpu_wdata = '0, per_bus_in = '0;
  logic per_stb_n = 1'b1, per_ack_n = 1'b1;
  logic [W-1:0] cpu_rdata, per_bus_out;
  logic per_bus_oe, obf_n, ibf, intr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bidir_hs_port #(.W(W), .SYNC(SYNC)) i_bidir_hs_port (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mode_set(mode_set),
    .bsr_valid(bsr_valid), .bsr_bit(bsr_bit), .bsr_val(bsr_val),
    .per_stb_n(per_stb_n), .per_ack_n(per_ack_n), .per_bus_in(per_bus_in),
    .per_bus_out(per_bus_out), .per_bus_oe(per_bus_oe), .obf_n(obf_n),
    .ibf(ibf), .intr(intr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bsr(input logic [2:0] b, input logic v);
    bsr_bit = b; bsr_val = v; bsr_valid = 1'b1;
    @(negedge clk);
    bsr_valid = 1'b0;
  endtask

  task automatic cpu_write(input logic [W-1:0] d);
    cpu_wdata = d; cpu_wr = 1'b1;
    #1 check("R10 intr low during write", intr, 0);
    idle(2);
    cpu_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic mode_pulse;
    mode_set = 1'b1;
    @(negedge clk);
    mode_set = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 obf_n", obf_n, 1);
    check("R1 ibf", ibf, 0);
    check("R1 intr", intr, 0);
    check("R1 oe", per_bus_oe, 0);
    cpu_write(8'h11);
    check("R1 output enable clear", intr, 0);
    mode_pulse();
  endtask

  task automatic t_write_ack(input logic [W-1:0] d);
    cpu_write(d);
    check("R2 obf_n low", obf_n, 0);
    check("R3 no drive before ack", per_bus_oe, 0);
    per_ack_n = 1'b0;
    idle(LAT);
    check("R3 oe during ack", per_bus_oe, 1);
    check("R3 bus data", per_bus_out, d);
    check("R4 obf held during ack", obf_n, 0);
    per_ack_n = 1'b1;
    idle(LAT);
    check("R4 obf_n released", obf_n, 1);
    check("R3 oe off after ack", per_bus_oe, 0);
  endtask

  task automatic t_strobe_read(input logic [W-1:0] d);
    per_bus_in = d; per_stb_n = 1'b0;
    idle(LAT);
    per_stb_n = 1'b1;
    per_bus_in = ~d;
    idle(LAT);
    check("R5 ibf set", ibf, 1);
    check("R5 rdata", cpu_rdata, d);
    cpu_rd = 1'b1;
    idle(2);
    check("R6 ibf held during read", ibf, 1);
    cpu_rd = 1'b0;
    @(negedge clk);
    check("R6 ibf cleared", ibf, 0);
  endtask

  task automatic t_bsr_ignore;
    for (int b = 0; b < 8; b++)
      if (b != 4 && b != 6) bsr(3'(b), 1'b1);
    cpu_write(8'h3C);
    check("R7 other bits leave output enable", intr, 0);
    per_bus_in = 8'h77; per_stb_n = 1'b0; idle(LAT); per_stb_n = 1'b1; idle(LAT);
    check("R7 other bits leave input enable", intr, 0);
    mode_pulse();
  endtask

  task automatic t_intr_out;
    bsr(3'd6, 1'b1);
    cpu_write(8'hA5);
    check("R9 intr from output term", intr, 1);
    cpu_wr = 1'b1;
    #1 check("R10 intr drops at write start", intr, 0);
    @(negedge clk); cpu_wr = 1'b0; @(negedge clk);
    per_ack_n = 1'b0; idle(LAT);
    check("R9 intr low while ack", intr, 0);
    per_ack_n = 1'b1; idle(LAT);
    check("R9 intr low once empty", intr, 0);
    bsr(3'd6, 1'b0);
    cpu_write(8'h5A);
    check("R7 bit 6 clear disables", intr, 0);
    mode_pulse();
  endtask

  task automatic t_intr_in;
    bsr(3'd4, 1'b1);
    per_bus_in = 8'hFF; per_stb_n = 1'b0; idle(LAT);
    check("R8 intr low while strobe", intr, 0);
    per_stb_n = 1'b1; idle(LAT);
    check("R8 intr from input term", intr, 1);
    cpu_rd = 1'b1;
    #1 check("R10 intr drops at read start", intr, 0);
    @(negedge clk); cpu_rd = 1'b0; @(negedge clk);
    check("R8 intr low after read", intr, 0);
    bsr(3'd4, 1'b0);
    per_stb_n = 1'b0; idle(LAT); per_stb_n = 1'b1; idle(LAT);
    check("R7 bit 4 clear disables", intr, 0);
    cpu_rd = 1'b1; @(negedge clk); cpu_rd = 1'b0; @(negedge clk);
  endtask

  task automatic t_mode;
    bsr(3'd6, 1'b1); bsr(3'd4, 1'b1);
    cpu_write(8'hC3);
    per_bus_in = 8'h81; per_stb_n = 1'b0; idle(LAT); per_stb_n = 1'b1; idle(LAT);
    mode_pulse();
    check("R11 obf_n", obf_n, 1);
    check("R11 ibf", ibf, 0);
    check("R11 intr", intr, 0);
    cpu_write(8'h42);
    per_stb_n = 1'b0; idle(LAT); per_stb_n = 1'b1; idle(LAT);
    check("R11 enables cleared", intr, 0);
    mode_pulse();
    per_ack_n = 1'b0; idle(LAT);
    check("R11 output latch cleared", per_bus_out, 0);
    per_ack_n = 1'b1; idle(LAT);
  endtask

  task automatic t_interleave;
    cpu_write(8'h00);
    per_bus_in = 8'hFF; per_stb_n = 1'b0; idle(LAT); per_stb_n = 1'b1; idle(LAT);
    check("R12 both flags", {obf_n, ibf}, 2'b01);
    per_ack_n = 1'b0; idle(LAT);
    check("R12 bus out while inbound full", per_bus_out, 8'h00);
    per_ack_n = 1'b1; idle(LAT);
    check("R12 ibf survives ack", ibf, 1);
    check("R12 rdata", cpu_rdata, 8'hFF);
    cpu_rd = 1'b1; @(negedge clk); cpu_rd = 1'b0; @(negedge clk);
    check("R12 both idle", {obf_n, ibf}, 2'b10);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_ack(8'hA5);
    t_write_ack(8'h5A);
    t_strobe_read(8'h3C);
    t_strobe_read(8'hFF);
    t_bsr_ignore();
    t_intr_out();
    t_intr_in();
    t_mode();
    t_interleave();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule